// File: doc/BRIEF.md
# Write-Through Invalidate Cache Controller

This block is the cache controller of one node on a shared bus whose transactions run atomically. It keeps a direct-mapped array of word lines. Each line is either valid or invalid. A processor read that finds its word resident is answered locally. A read that misses takes the bus, fetches the word from memory, fills the line and marks it valid. Every processor write goes through to memory as a bus write. A write that hits also refreshes the local copy. A write that misses leaves the cache untouched.

The block also watches the transactions that other nodes put on the bus. When another node writes an address whose line is held valid here with the same full tag, the line drops to invalid. Because every write reaches memory and every foreign write kills the stale copy, a later local read always returns the newest memory value.

The processor issues one operation at a time and waits for its response. The bus side is a request/grant handshake. After the grant, the node holds the bus until the memory responder acknowledges. For a read, that acknowledge carries the fill word.

Top module: `wtc_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address goes to the bus; `cpu_resp_valid` and `bus_req` are low and `cpu_req_ready` is high.
- R2: A read whose index holds a valid line with a matching tag raises `cpu_resp_valid` with the line's word in the cycle after acceptance, and no bus transaction occurs.
- R3: A read miss raises `bus_req` with `bus_we` low and the request address. The response carries `mem_rdata` in the cycle after `mem_ack`, and the line becomes valid, so an immediate re-read hits.
- R4: Every write, hit or miss, produces exactly one bus transaction with `bus_we` high and the processor's address and data. Its response comes in the cycle after `mem_ack`.
- R5: A write miss allocates nothing. The line at that index keeps its earlier tag and validity, and a later read of the written address still misses.
- R6: A write hit stores the new word in the line, which stays valid. A following read of that address hits without bus activity and returns the new word.
- R7: A snooped write (`snp_valid` and `snp_we` high) from a node other than `NODE_ID`, whose full address matches a valid line, invalidates that line. The next local read of it misses and returns the memory value.
- R8: A snoop is ignored when `snp_node` equals `NODE_ID`, when `snp_we` is low, or when the tag differs from the line's tag; the line keeps hitting.
- R9: From acceptance of a bus-bound request until its `mem_ack`, `bus_req` stays high with stable address, command and data, and `cpu_req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request strobe, taken when ready is high |
| cpu_req_ready | output | 1 | Controller idle and able to take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address; low IDX_W bits index the line, the rest form the tag |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word (write word echoed for writes) |
| bus_req | output | 1 | Bus wanted / held until acknowledge |
| bus_gnt | input | 1 | Bus granted to this node |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-through word |
| mem_ack | input | 1 | Memory finished the transaction |
| mem_rdata | input | DATA_W | Fill word, valid with mem_ack on reads |
| snp_valid | input | 1 | An observed bus transaction is present |
| snp_we | input | 1 | Observed transaction is a write |
| snp_node | input | NODE_W | Node that issued the observed transaction |
| snp_addr | input | ADDR_W | Observed address |

## Verification
A read hit must answer exactly one cycle after the accepting edge. The bench therefore samples `cpu_resp_valid` on the first falling edge after it drives the request, and a late or early answer is reported. Bus-bound operations must answer exactly one cycle after `mem_ack`. The bench keeps a posedge cycle counter, notes the cycle in which it acknowledged, and requires the response to appear on the falling edge in which that counter is one higher. A snoop takes effect at the next rising edge. It is driven for a single cycle before the next processor request, whose hit or miss (counted through the bus transactions the responder grants) shows whether the line survived.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  sn_idx,
  output logic              sn_valid,
  output logic [TAG_W-1:0]  sn_tag,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              inval_en,
  input  logic [IDX_W-1:0]  inval_idx
);
  localparam int LINES = 1 << IDX_W;

  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] LI = IDX_W'(i);
    logic fill_here, upd_here, kill_here, valid_d;

    always_comb begin
      fill_here = fill_en  && (fill_idx  == LI);
      upd_here  = upd_en   && (upd_idx   == LI);
      kill_here = inval_en && (inval_idx == LI);
      valid_d   = valid_q[i];
      if (fill_here) valid_d = 1'b1;
      if (kill_here) valid_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[i] <= 1'b0;
      else        valid_q[i] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (fill_here) tag_q[i] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (fill_here)     data_q[i] <= fill_data;
      else if (upd_here) data_q[i] <= upd_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign sn_valid = valid_q[sn_idx];
  assign sn_tag   = tag_q[sn_idx];

  // R3: a fill leaves its line valid unless a kill hits the same line
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !(inval_en && inval_idx == fill_idx) |=> valid_q[$past(fill_idx)]);

  // R7: an accepted snoop kill leaves the line invalid
  a_r7_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inval_en |=> !valid_q[$past(inval_idx)]);

  // R6: a write-hit update keeps the line valid and holds the new word
  a_r6_update_keeps_line: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && valid_q[upd_idx] && !(inval_en && inval_idx == upd_idx)
    |=> valid_q[$past(upd_idx)] && data_q[$past(upd_idx)] == $past(upd_data));
endmodule

// File: rtl/wtc_snoop_filter.sv
module wtc_snoop_filter #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int NODE_W = 2,
  parameter logic [NODE_W-1:0] NODE_ID = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snp_valid,
  input  logic                snp_we,
  input  logic [NODE_W-1:0]   snp_node,
  input  logic [ADDR_W-1:0]   snp_addr,
  output logic [IDX_W-1:0]    sn_idx,
  input  logic                sn_valid,
  input  logic [ADDR_W-IDX_W-1:0] sn_tag,
  output logic                inval_en,
  output logic [IDX_W-1:0]    inval_idx
);
  logic foreign_wr, tag_eq;

  always_comb begin
    sn_idx     = snp_addr[IDX_W-1:0];
    foreign_wr = snp_valid && snp_we && (snp_node != NODE_ID);
    tag_eq     = (sn_tag == snp_addr[ADDR_W-1:IDX_W]);
    inval_en   = foreign_wr && sn_valid && tag_eq;
    inval_idx  = sn_idx;
  end

  // R8: the node's own transactions never kill a line
  a_r8_own_node_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_node == NODE_ID |-> !inval_en);

  // R8: observed reads never kill a line
  a_r8_reads_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_we |-> !inval_en);
endmodule

// File: rtl/wtc_ctrl_fsm.sv
module wtc_ctrl_fsm
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_we,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [DATA_W-1:0]       cpu_req_wdata,
  output logic                    cpu_resp_valid,
  output logic [DATA_W-1:0]       cpu_resp_rdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    bus_we,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic [IDX_W-1:0]        lk_idx,
  input  logic                    lk_valid,
  input  logic [ADDR_W-IDX_W-1:0] lk_tag,
  input  logic [DATA_W-1:0]       lk_data,
  output logic                    fill_en,
  output logic [IDX_W-1:0]        fill_idx,
  output logic [ADDR_W-IDX_W-1:0] fill_tag,
  output logic [DATA_W-1:0]       fill_data,
  output logic                    upd_en,
  output logic [IDX_W-1:0]        upd_idx,
  output logic [DATA_W-1:0]       upd_data
);
  wtc_state_e state_q, state_d;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              resp_valid_q, resp_valid_d;
  logic [DATA_W-1:0] resp_data_q, resp_data_d;

  logic [ADDR_W-1:0] cur_addr;
  logic accept, hit, fast_hit, go_bus, done;

  always_comb begin
    cur_addr = (state_q == ST_IDLE) ? cpu_req_addr : req_addr_q;
    lk_idx   = cur_addr[IDX_W-1:0];
    hit      = lk_valid && (lk_tag == cur_addr[ADDR_W-1:IDX_W]);
    accept   = (state_q == ST_IDLE) && cpu_req_valid;
    fast_hit = accept && !cpu_req_we && hit;
    go_bus   = accept && !fast_hit;
    done     = (state_q == ST_WAIT) && mem_ack;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_bus)  state_d = ST_REQ;
      ST_REQ:  if (bus_gnt) state_d = ST_WAIT;
      ST_WAIT: if (mem_ack) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase

    fill_en   = done && !req_we_q;
    fill_idx  = req_addr_q[IDX_W-1:0];
    fill_tag  = req_addr_q[ADDR_W-1:IDX_W];
    fill_data = mem_rdata;
    upd_en    = done && req_we_q && hit;
    upd_idx   = req_addr_q[IDX_W-1:0];
    upd_data  = req_wdata_q;

    resp_valid_d = fast_hit || done;
    if (fast_hit)      resp_data_d = lk_data;
    else if (req_we_q) resp_data_d = req_wdata_q;
    else               resp_data_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      resp_valid_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      resp_valid_q <= resp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (go_bus) begin
      req_we_q    <= cpu_req_we;
      req_addr_q  <= cpu_req_addr;
      req_wdata_q <= cpu_req_wdata;
    end
    if (resp_valid_d) resp_data_q <= resp_data_d;
  end

  assign cpu_req_ready  = (state_q == ST_IDLE);
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_rdata = resp_data_q;
  assign bus_req        = (state_q != ST_IDLE);
  assign bus_we         = req_we_q;
  assign bus_addr       = req_addr_q;
  assign bus_wdata      = req_wdata_q;

  // R2: a read hit answers next cycle and leaves the bus alone
  a_r2_hit_is_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && !cpu_req_we && hit |=> cpu_resp_valid && !bus_req);

  // R4: a bus operation answers the cycle after the memory acknowledge
  a_r4_resp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && state_q == ST_WAIT && mem_ack |=> cpu_resp_valid && !bus_req);

  // R9: the bus is held with a steady transaction until the acknowledge
  a_r9_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(state_q == ST_WAIT && mem_ack)
    |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R1: nothing answers without a request having been taken
  a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req_valid && !bus_req |=> !cpu_resp_valid);
endmodule

// File: rtl/wtc_snoop_cache.sv
module wtc_snoop_cache #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  parameter int NODE_W = 2,
  parameter logic [NODE_W-1:0] NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [NODE_W-1:0] snp_node,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, sn_idx, fill_idx, upd_idx, inval_idx;
  logic              lk_valid, sn_valid, fill_en, upd_en, inval_en;
  logic [TAG_W-1:0]  lk_tag, sn_tag, fill_tag;
  logic [DATA_W-1:0] lk_data, fill_data, upd_data;

  wtc_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_data(fill_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data)
  );

  wtc_snoop_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NODE_W(NODE_W),
                     .NODE_ID(NODE_ID)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_node(snp_node),
    .snp_addr(snp_addr),
    .sn_idx(sn_idx), .sn_valid(sn_valid), .sn_tag(sn_tag),
    .inval_en(inval_en), .inval_idx(inval_idx)
  );

  wtc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_tag(lk_tag), .rd_data(lk_data),
    .sn_idx(sn_idx), .sn_valid(sn_valid), .sn_tag(sn_tag),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_data(fill_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .inval_en(inval_en), .inval_idx(inval_idx)
  );

  // R5: a write never fills a line
  a_r5_write_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> !fill_en);
endmodule

// File: tb/tb_wtc_snoop_cache.sv
module tb_wtc_snoop_cache;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 16;
  localparam int NODE_W = 2;
  localparam logic [NODE_W-1:0] OWN = 2'd1;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_resp_valid, bus_req, bus_we;
  logic [DATA_W-1:0] cpu_resp_rdata, bus_wdata;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_gnt = 1'b0, mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic snp_valid = 1'b0, snp_we = 1'b0;
  logic [NODE_W-1:0] snp_node = '0;
  logic [ADDR_W-1:0] snp_addr = '0;

  always #5 clk = ~clk;

  wtc_snoop_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
                    .NODE_W(NODE_W), .NODE_ID(OWN)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_node(snp_node),
    .snp_addr(snp_addr)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int cyc = 0, ack_cyc = -10;
  int n_rd = 0, n_wr = 0;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_wdata;
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  bit m_valid [LINES];
  logic [ADDR_W-IDX_W-1:0] m_tag [LINES];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_ack) ack_cyc <= cyc;
  end

  function automatic logic [DATA_W-1:0] seed_word(input int a);
    return DATA_W'(a * 37) ^ 16'h5a5a;
  endfunction

  function automatic bit model_hit(input logic [ADDR_W-1:0] a);
    return m_valid[a[IDX_W-1:0]] && m_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory responder: grant after a random wait, acknowledge after another
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && rst_n) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        bus_gnt = 1'b1;
        if (bus_we) n_wr++; else n_rd++;
        last_addr  = bus_addr;
        last_wdata = bus_wdata;
        @(negedge clk);
        bus_gnt = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        mem_rdata = mem[bus_addr];
        if (bus_we) mem[bus_addr] = bus_wdata;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, input string rq);
    bit hit_exp;
    int rd0, wr0, guard;
    logic [DATA_W-1:0] exp_data;
    hit_exp = model_hit(a);
    rd0 = n_rd; wr0 = n_wr;
    exp_data = we ? wd : mem[a];
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (!we && hit_exp) begin
      chk(cpu_resp_valid === 1'b1, rq, "hit answer one cycle after accept",
          32'(cpu_resp_valid), 1);
      chk(cpu_resp_rdata === exp_data, rq, "hit data", 32'(cpu_resp_rdata), 32'(exp_data));
      chk(n_rd == rd0 && n_wr == wr0, rq, "hit made bus traffic",
          32'(n_rd + n_wr - rd0 - wr0), 0);
    end else begin
      chk(cpu_req_ready === 1'b0 && bus_req === 1'b1, "R9",
          "busy while bus-bound", 32'({cpu_req_ready, bus_req}), 32'b01);
      guard = 0;
      while (cpu_resp_valid !== 1'b1 && guard < 50) begin
        @(negedge clk);
        guard++;
        if (cpu_resp_valid !== 1'b1)
          if (cpu_req_ready !== 1'b0) begin
            chk(1'b0, "R9", "ready rose before answer", 32'(cpu_req_ready), 0);
          end
      end
      chk(cpu_resp_valid === 1'b1 && cyc == ack_cyc + 1, rq,
          "answer one cycle after acknowledge", 32'(cyc), 32'(ack_cyc + 1));
      if (!we) begin
        chk(cpu_resp_rdata === exp_data, rq, "fill data", 32'(cpu_resp_rdata), 32'(exp_data));
        chk(n_rd == rd0 + 1 && n_wr == wr0 && last_addr == a, rq,
            "one bus read at request address", 32'(n_rd - rd0), 1);
        m_valid[a[IDX_W-1:0]] = 1'b1;
        m_tag[a[IDX_W-1:0]] = a[ADDR_W-1:IDX_W];
      end else begin
        chk(n_wr == wr0 + 1 && n_rd == rd0, rq, "one bus write", 32'(n_wr - wr0), 1);
        chk(last_addr == a && last_wdata == wd, rq, "write-through data",
            32'(last_wdata), 32'(wd));
      end
    end
  endtask

  task automatic snoop(input bit we, input logic [NODE_W-1:0] node,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    snp_valid = 1'b1; snp_we = we; snp_node = node; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    if (we && node != OWN) begin
      mem[a] = d;
      if (model_hit(a)) m_valid[a[IDX_W-1:0]] = 1'b0;
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int tg, input int ix);
    return ADDR_W'((tg << IDX_W) | ix);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a_x, b_x;
    void'($urandom(32'd4021));
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = seed_word(i);
    for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cpu_resp_valid === 1'b0 && bus_req === 1'b0 && cpu_req_ready === 1'b1, "R1",
        "reset outputs", 32'({cpu_resp_valid, bus_req, cpu_req_ready}), 32'b001);
    rst_n = 1'b1;
    @(negedge clk);
    a_x = mk_addr(0, 5);
    b_x = mk_addr(8, 5);
    cpu_op(1'b0, a_x, '0, "R1");            // first read must miss
    cpu_op(1'b0, a_x, '0, "R2");            // now hits (R3 fill)
    cpu_op(1'b1, a_x, 16'hbeef, "R4");      // write hit goes through
    cpu_op(1'b0, a_x, '0, "R6");            // hit returns new word
    cpu_op(1'b1, b_x, 16'h1234, "R5");      // write miss, same index
    cpu_op(1'b0, a_x, '0, "R5");            // old line still hits
    cpu_op(1'b0, b_x, '0, "R5");            // written address still misses
    cpu_op(1'b0, a_x, '0, "R3");            // refill a
    snoop(1'b1, 2'd2, b_x, 16'h7777);       // tag differs
    cpu_op(1'b0, a_x, '0, "R8");
    snoop(1'b1, OWN, a_x, 16'h0);           // own node
    cpu_op(1'b0, a_x, '0, "R8");
    snoop(1'b0, 2'd3, a_x, 16'h0);          // observed read
    cpu_op(1'b0, a_x, '0, "R8");
    snoop(1'b1, 2'd0, a_x, 16'h4242);       // foreign write kills
    cpu_op(1'b0, a_x, '0, "R7");
    cpu_op(1'b0, a_x, '0, "R7");
    for (int k = 0; k < 400; k++) begin
      logic [ADDR_W-1:0] ra;
      int pick;
      ra = mk_addr(int'($urandom_range(0, 3)), int'($urandom_range(0, LINES - 1)));
      pick = int'($urandom_range(0, 9));
      if (pick < 5)      cpu_op(1'b0, ra, '0, "R3");
      else if (pick < 8) cpu_op(1'b1, ra, DATA_W'($urandom), "R4");
      else               snoop(1'b1, NODE_W'($urandom_range(0, 3)), ra, DATA_W'($urandom));
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule